// File: doc/BRIEF.md
# Serial Control Register Loader

This block is a three-wire serial slave that configures an analog front end. A host pulls a frame-enable line low, then presents thirteen bits on a data line, one bit for each rising edge of a serial clock. The first three bits select a control register and the last ten carry its value. When the enable line goes high again, the block copies the low-order bits that the selected register holds into that register.

The block runs on a fast system clock. The three serial pins pass through two-flop synchronizers, and the block detects their edges in the system clock domain. The serial clock may run at no more than a quarter of the system clock rate. The outputs are the five register contents and three decoded power-down enables, all held steady between frames.

Top module: `afe_ser_loader`

## Requirements
- R1: A frame is 13 serial clock rising edges taken while `sen_n` is low. The first 3 bits form the address, most significant bit first. The next 10 bits form the data, most significant bit first.
- R2: Address 3'b000 loads all 10 data bits into `clamp_code`.
- R3: Address 3'b001 loads data bits 7..0 into `bw_code`.
- R4: Address 3'b010 loads data bits 8..0 into `gain_code`.
- R5: Address 3'b100 loads data bits 7..0 into `drain_code`.
- R6: Address 3'b011 loads data bits 3..0 into `sby_ctl` and ignores data bits 9..4. The decoded outputs follow the held bits: `sby_fe` is bit 0, `sby_drain` is bit 1 and `sby_amp` is bit 2, each high meaning standby.
- R7: A frame addressed to 3'b101, 3'b110 or 3'b111 changes no output.
- R8: A frame of fewer than 13 bits is dropped and every output keeps its value.
- R9: A frame of more than 13 bits is dropped and every output keeps its value.
- R10: Registers change only after the rising edge of `sen_n`. While the frame is still open, the outputs hold their previous values even when all 13 bits have arrived.
- R11: A synchronous high `rst` clears every register, so every code and every standby output reads zero.
- R12: Serial clock edges while `sen_n` is high are not counted and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sen_n | input | 1 | Frame enable, low while a frame is sent |
| sclk_i | input | 1 | Serial bit clock, sampled on its rising edge |
| sdat_i | input | 1 | Serial data |
| clamp_code | output | 10 | Clamp level code |
| bw_code | output | 8 | Bandwidth code |
| gain_code | output | 9 | Gain code |
| drain_code | output | 8 | Overflow-drain level code |
| sby_ctl | output | 4 | Standby and edge-control bits |
| sby_fe | output | 1 | Sampler and gain stage in standby |
| sby_drain | output | 1 | Drain level converter in standby |
| sby_amp | output | 1 | Auxiliary output amplifier in standby |

## Verification
The bench sends frames of 12, 1 and 14 bits. A loader that commits whenever it reaches a bit count, rather than requiring exactly thirteen, would corrupt a register on these frames. It writes to the three unmapped addresses, which catches a decoder with a default branch that lands in a real register. It writes the standby register with its upper data bits set, which catches width slips that keep the wrong slice. It also samples the outputs after the thirteenth bit but before the enable rises, and it pulses the serial clock while the frame is closed. These two steps expose a design that commits early or counts stray edges into the next frame.

// File: rtl/afe_loader_pkg.sv
package afe_loader_pkg;

    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 10;
    localparam int FRAME_LEN = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);

    localparam int CLAMP_W = 10;
    localparam int BW_W    = 8;
    localparam int GAIN_W  = 9;
    localparam int DRAIN_W = 8;
    localparam int SBY_W   = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CLAMP = 3'b000,
        RA_BW    = 3'b001,
        RA_GAIN  = 3'b010,
        RA_SBY   = 3'b011,
        RA_DRAIN = 3'b100
    } reg_addr_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic [CLAMP_W-1:0] clamp;
        logic [BW_W-1:0]    bw;
        logic [GAIN_W-1:0]  gain;
        logic [DRAIN_W-1:0] drain;
        logic [SBY_W-1:0]   sby;
    } ctl_regs_t;

    // Standby bit positions inside the standby register
    localparam int SBY_FE_BIT    = 0;
    localparam int SBY_DRAIN_BIT = 1;
    localparam int SBY_AMP_BIT   = 2;

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        return (a == RA_CLAMP) || (a == RA_BW) || (a == RA_GAIN) ||
               (a == RA_SBY)   || (a == RA_DRAIN);
    endfunction

endpackage

// File: rtl/afe_pin_sync.sv
module afe_pin_sync #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[i]}};
            else     chain <= {chain[STAGES-2:0], din[i]};
        end
        assign dout[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/afe_frame_shifter.sv
module afe_frame_shifter
    import afe_loader_pkg::*;
#(
    parameter int LEN = FRAME_LEN,
    parameter int CW  = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_n_s,
    input  logic          sck_s,
    input  logic          sd_s,
    output logic          frm_valid,
    output frame_t        frm,
    output logic [CW-1:0] bit_cnt
);

    localparam logic [CW-1:0] CNT_FULL = CW'(LEN);
    localparam logic [CW-1:0] CNT_OVER = CW'(LEN + 1);

    logic           en_prev, sck_prev;
    logic           en_rise, sck_rise;
    logic [LEN-1:0] word_q, frm_q;
    logic [CW-1:0]  cnt_q;
    logic           valid_q;

    assign en_rise  = en_n_s & ~en_prev;
    assign sck_rise = sck_s & ~sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            en_prev  <= en_n_s;
            sck_prev <= sck_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            frm_q   <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (en_n_s) begin
                // frame closed: commit a complete frame, always restart count
                if (en_rise && cnt_q == CNT_FULL) begin
                    valid_q <= 1'b1;
                    frm_q   <= word_q;
                end
                cnt_q <= '0;
            end else if (sck_rise) begin
                word_q <= {word_q[LEN-2:0], sd_s};
                if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign frm_valid = valid_q;
    assign frm       = frame_t'(frm_q);
    assign bit_cnt   = cnt_q;

endmodule

// File: rtl/afe_reg_bank.sv
module afe_reg_bank
    import afe_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_valid,
    input  frame_t    wr_frm,
    output ctl_regs_t regs
);

    ctl_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_valid && addr_mapped(wr_frm.addr)) begin
            case (wr_frm.addr)
                RA_CLAMP: regs_q.clamp <= wr_frm.data[CLAMP_W-1:0];
                RA_BW:    regs_q.bw    <= wr_frm.data[BW_W-1:0];
                RA_GAIN:  regs_q.gain  <= wr_frm.data[GAIN_W-1:0];
                RA_SBY:   regs_q.sby   <= wr_frm.data[SBY_W-1:0];
                RA_DRAIN: regs_q.drain <= wr_frm.data[DRAIN_W-1:0];
                default:  regs_q       <= regs_q;
            endcase
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/afe_ser_loader.sv
module afe_ser_loader
    import afe_loader_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sen_n,
    input  logic               sclk_i,
    input  logic               sdat_i,
    output logic [CLAMP_W-1:0] clamp_code,
    output logic [BW_W-1:0]    bw_code,
    output logic [GAIN_W-1:0]  gain_code,
    output logic [DRAIN_W-1:0] drain_code,
    output logic [SBY_W-1:0]   sby_ctl,
    output logic               sby_fe,
    output logic               sby_drain,
    output logic               sby_amp
);

    logic [2:0]       pins_s;
    logic             frm_valid;
    frame_t           frm;
    logic [CNT_W-1:0] bit_cnt;
    ctl_regs_t        regs_q;

    // pin order: {data, serial clock, enable}; enable idles high
    afe_pin_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sdat_i, sclk_i, sen_n}),
        .dout (pins_s)
    );

    afe_frame_shifter #(
        .LEN (FRAME_LEN),
        .CW  (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .en_n_s    (pins_s[0]),
        .sck_s     (pins_s[1]),
        .sd_s      (pins_s[2]),
        .frm_valid (frm_valid),
        .frm       (frm),
        .bit_cnt   (bit_cnt)
    );

    afe_reg_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (frm_valid),
        .wr_frm   (frm),
        .regs     (regs_q)
    );

    assign clamp_code = regs_q.clamp;
    assign bw_code    = regs_q.bw;
    assign gain_code  = regs_q.gain;
    assign drain_code = regs_q.drain;
    assign sby_ctl    = regs_q.sby;
    assign sby_fe     = regs_q.sby[SBY_FE_BIT];
    assign sby_drain  = regs_q.sby[SBY_DRAIN_BIT];
    assign sby_amp    = regs_q.sby[SBY_AMP_BIT];

endmodule

// File: rtl/afe_loader_chk.sv
module afe_loader_chk
    import afe_loader_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frm_valid,
    input logic [ADDR_W-1:0] frm_addr,
    input logic [DATA_W-1:0] frm_data,
    input logic [CNT_W-1:0]  bit_cnt,
    input ctl_regs_t         regs
);

    // R10
    hold_between_frames_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> $stable(regs));

    // R8
    exact_len_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> $past(bit_cnt) == CNT_W'(FRAME_LEN));

    // R7
    unmapped_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_addr > 3'b100) |=> $stable(regs));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> regs == '0);

    // R6
    sby_slice_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_addr == RA_SBY) |=> regs.sby == $past(frm_data[SBY_W-1:0]));

    // R4
    gain_slice_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_addr == RA_GAIN) |=> regs.gain == $past(frm_data[GAIN_W-1:0]));

    // R2
    clamp_full_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_addr == RA_CLAMP) |=> regs.clamp == $past(frm_data));

endmodule

bind afe_ser_loader afe_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .frm_valid (frm_valid),
    .frm_addr  (frm.addr),
    .frm_data  (frm.data),
    .bit_cnt   (bit_cnt),
    .regs      (regs_q)
);

// File: tb/tb_afe_ser_loader.sv
module tb_afe_ser_loader;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sen_n = 1'b1;
    logic       sclk_i = 1'b0;
    logic       sdat_i = 1'b0;
    logic [9:0] clamp_code;
    logic [7:0] bw_code;
    logic [8:0] gain_code;
    logic [7:0] drain_code;
    logic [3:0] sby_ctl;
    logic       sby_fe, sby_drain, sby_amp;

    always #10 clk = ~clk;

    afe_ser_loader dut (
        .clk(clk), .rst(rst), .sen_n(sen_n), .sclk_i(sclk_i), .sdat_i(sdat_i),
        .clamp_code(clamp_code), .bw_code(bw_code), .gain_code(gain_code),
        .drain_code(drain_code), .sby_ctl(sby_ctl), .sby_fe(sby_fe),
        .sby_drain(sby_drain), .sby_amp(sby_amp)
    );

    typedef struct {
        logic [9:0] clamp;
        logic [7:0] bw;
        logic [8:0] gain;
        logic [7:0] drain;
        logic [3:0] sby;
        string      tag;
    } exp_t;

    exp_t model;
    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    task automatic chk(string tag, string nm, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic cmp(exp_t e);
        chk(e.tag, "clamp_code", 16'(clamp_code), 16'(e.clamp));
        chk(e.tag, "bw_code",    16'(bw_code),    16'(e.bw));
        chk(e.tag, "gain_code",  16'(gain_code),  16'(e.gain));
        chk(e.tag, "drain_code", 16'(drain_code), 16'(e.drain));
        chk(e.tag, "sby_ctl",    16'(sby_ctl),    16'(e.sby));
        chk(e.tag, "sby_fe",     16'(sby_fe),     16'(e.sby[0]));
        chk(e.tag, "sby_drain",  16'(sby_drain),  16'(e.sby[1]));
        chk(e.tag, "sby_amp",    16'(sby_amp),    16'(e.sby[2]));
    endtask

    // one serial bit: data set up with clock low, then 4 cycles high
    task automatic put_bit(logic b);
        sdat_i = b;
        repeat (4) @(negedge clk);
        sclk_i = 1'b1;
        repeat (4) @(negedge clk);
        sclk_i = 1'b0;
    endtask

    // driver: sends nbits of {addr,data} MSB first (extra bits are zero),
    // updates the model only for a 13-bit frame, pushes the expectation
    task automatic send_frame(int nbits, logic [2:0] addr, logic [9:0] data,
                              string tag, bit hold_chk = 1'b0);
        logic [12:0] word;
        word = {addr, data};
        @(negedge clk);
        sen_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) put_bit(i < 13 ? word[12-i] : 1'b0);
        repeat (4) @(negedge clk);
        if (hold_chk) begin
            // R10: all bits in, enable still low, nothing committed yet
            repeat (8) @(negedge clk);
            model.tag = tag;
            cmp(model);
        end
        sen_n = 1'b1;
        if (nbits == 13) begin
            case (addr)
                3'b000: model.clamp = data;
                3'b001: model.bw    = data[7:0];
                3'b010: model.gain  = data[8:0];
                3'b011: model.sby   = data[3:0];
                3'b100: model.drain = data[7:0];
                default: ;
            endcase
        end
        model.tag = tag;
        exp_q.push_back(model);
        repeat (14) @(negedge clk);
    endtask

    // monitor: pops each expectation once the design has settled
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                repeat (10) @(negedge clk);
                e = exp_q.pop_front();
                cmp(e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model = '{clamp: '0, bw: '0, gain: '0, drain: '0, sby: '0, tag: "R11"};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        model.tag = "R11 reset";
        cmp(model);

        send_frame(13, 3'b000, 10'h2A5, "R2 clamp");
        send_frame(13, 3'b000, 10'h201, "R1 msb first");
        send_frame(13, 3'b001, 10'h3C6, "R3 bw");
        send_frame(13, 3'b010, 10'h2F3, "R4 gain");
        send_frame(13, 3'b010, 10'h1FF, "R4 gain full");
        send_frame(13, 3'b100, 10'h15A, "R5 drain");
        send_frame(13, 3'b011, 10'h3F5, "R6 sby upper ignored");
        send_frame(13, 3'b011, 10'h00A, "R6 sby decode");
        send_frame(13, 3'b101, 10'h3FF, "R7 addr 101");
        send_frame(13, 3'b110, 10'h3FF, "R7 addr 110");
        send_frame(13, 3'b111, 10'h3FF, "R7 addr 111");
        send_frame(12, 3'b010, 10'h0AA, "R8 twelve bits");
        send_frame(1,  3'b000, 10'h3FF, "R8 one bit");
        send_frame(14, 3'b000, 10'h155, "R9 fourteen bits");
        send_frame(13, 3'b001, 10'h081, "R10 hold", 1'b1);

        // R12: serial clock pulses with the frame closed
        for (int k = 0; k < 5; k++) put_bit(1'b1);
        repeat (4) @(negedge clk);
        model.tag = "R12 stray edges";
        cmp(model);
        send_frame(13, 3'b100, 10'h0C3, "R12 next frame");

        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model = '{clamp: '0, bw: '0, gain: '0, drain: '0, sby: '0, tag: "R11 reset again"};
        cmp(model);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule